// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

The block runs one external memory bus cycle at a time on a bus whose sixteen low lines carry first the address and then the data, plus four dedicated upper address lines. One clock is one quarter-phase. A cycle is an address phase, a turnaround phase, a data phase, an optional run of wait blocks and a closing phase. Each wait block is four clocks long. The same bus cycle serves instruction fetches, table reads and table writes.

A request is presented with `req_valid`. The sequencer takes it only when it is idle or in the closing phase of the cycle in progress, so cycles can run back to back with no gap. At the moment of acceptance it latches the request kind, the 21-bit byte address, the write data and the decoded wait count. An outside latch captures the word address from the low lines while `ale` is high. Read data is taken from `ad_in` at the edge where `oe_n` rises.

The state machine has these states:

- `PH_IDLE`: no cycle is running.
- `PH_ADDR`: Q1, the address phase.
- `PH_TURN`: Q2, the turnaround phase.
- `PH_DATA`: Q3, the start of the data phase.
- `PH_WAIT`: the wait blocks.
- `PH_LAST`: Q4, the closing phase.

Its transitions are:

- IDLE→ADDR on acceptance.
- ADDR→TURN and TURN→DATA unconditionally.
- DATA→WAIT when the wait count is nonzero, otherwise DATA→LAST.
- WAIT→WAIT while the wait counter is nonzero, otherwise WAIT→LAST.
- LAST→ADDR on acceptance, otherwise LAST→IDLE.

Top module: `extbus_seq`

## Requirements
- R1: After reset and whenever idle: `ce_n`, `oe_n` and `wr_n` are 1; `ale`, `ba0`, `ad_oe` and `done` are 0; `addr_hi` is 0. After reset, `rd_data` is 0.
- R2: During a cycle `ce_n` is 0 and `addr_hi` shows address bits [20:17] in every phase. `ale` is 1 only in the address phase. In that phase `ad_oe` is 1 and `ad_out` carries address bits [16:1].
- R3: For a fetch (`req_kind` 00) or a table read (01), the low lines are released (`ad_oe` 0) from the turnaround phase on. `oe_n` is 0 from the data phase through the closing phase, including every wait clock, and it is 1 in the first two phases.
- R4: On a read or fetch, `ad_in` is captured at the clock edge that ends the closing phase, where `oe_n` rises. The captured value appears on `rd_data` from the next clock and is held until the next read or fetch completes. A table write leaves `rd_data` unchanged.
- R5: For a fetch, `ba0` is 1 only in the data phase (Q3, not in wait clocks) and only when address bit 0 is 1. For a table read or write, `ba0` equals address bit 0 throughout the cycle.
- R6: For a table write (`req_kind` 10), `oe_n` stays 1 for the whole cycle. `wr_n` is 0 and `ad_out` drives the latched `wr_data` with `ad_oe` 1 from the data phase through the closing phase. The low lines are released in the turnaround phase.
- R7: With `wait_en` 1, `wait_sel` selects the number of four-clock wait blocks inserted between the data phase and the closing phase: 11 gives 0, 10 gives 1, 01 gives 2 and 00 gives 3.
- R8: With `wait_en` 0, no wait block is inserted, whatever the value of `wait_sel`.
- R9: `done` is 1 exactly in the closing phase. A request held in the closing phase starts its address phase on the next clock. A request raised in any other busy phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one quarter-phase |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 table read, 10 table write, 11 handled as a table read |
| req_addr | input | 21 | Byte address |
| wr_data | input | 16 | Word driven during a table write |
| wait_en | input | 1 | Enables wait blocks |
| wait_sel | input | 2 | Wait count code |
| ad_in | input | 16 | Value read from the low lines |
| ad_out | output | 16 | Value driven on the low lines |
| ad_oe | output | 1 | Output enable for the low lines |
| addr_hi | output | 4 | Upper address lines |
| ale | output | 1 | Address latch enable |
| oe_n | output | 1 | Active-low output enable to memory |
| wr_n | output | 1 | Active-low write strobe window |
| ce_n | output | 1 | Active-low chip enable |
| ba0 | output | 1 | Byte address bit |
| rd_data | output | 16 | Last captured read word |
| done | output | 1 | High in the closing phase |

## Verification
Two things can happen in the same clock: a cycle finishes (`done`, and the read capture at the rising `oe_n`), and a new request is accepted. The bench sets this up by presenting the next request during the closing phase of a cycle. It then expects `ale` in the very next clock and the full phase pattern of the new cycle, and it checks `rd_data` against the earlier read once the chain ends. It also raises requests during the turnaround phase and expects the cycle to end in idle with no extra address phase.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_TRD   = 2'b01,
        KIND_TWR   = 2'b10,
        KIND_RSV   = 2'b11
    } bus_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_TURN,
        PH_DATA,
        PH_WAIT,
        PH_LAST
    } bus_phase_e;

endpackage

// File: rtl/extbus_wait_dec.sv
module extbus_wait_dec #(
    parameter int SEL_W = 2
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [SEL_W-1:0] cycles
);
    // code is the bitwise complement of the block count; disabled means zero
    always_comb begin
        cycles = en ? ~sel : '0;
    end
endmodule

// File: rtl/extbus_phase_fsm.sv
module extbus_phase_fsm
    import extbus_pkg::*;
#(
    parameter int WCYC_W    = 2,
    parameter int Q_PER_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [WCYC_W-1:0] wait_cycles,
    output bus_phase_e        phase
);
    localparam int MAX_TICKS = ((1 << WCYC_W) - 1) * Q_PER_CYC;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    bus_phase_e       phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: if (accept) phase_d = PH_ADDR;
            PH_ADDR: phase_d = PH_TURN;
            PH_TURN: phase_d = PH_DATA;
            PH_DATA: begin
                if (wait_cycles != '0) begin
                    phase_d = PH_WAIT;
                    cnt_d   = CNT_W'(int'(wait_cycles) * Q_PER_CYC - 1);
                end else begin
                    phase_d = PH_LAST;
                end
            end
            PH_WAIT: begin
                if (cnt_q == '0) phase_d = PH_LAST;
                else             cnt_d   = cnt_q - 1'b1;
            end
            PH_LAST: phase_d = accept ? PH_ADDR : PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    assign phase = phase_q;

    // R8: zero wait count goes straight from data phase to closing phase
    p_no_wait_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA && wait_cycles == '0) |=> (phase_q == PH_LAST));
    // R7: wait state persists while its counter has ticks left
    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WAIT && cnt_q != '0) |=> (phase_q == PH_WAIT));
    // R7: data phase with a nonzero count always enters a wait block
    p_wait_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA && wait_cycles != '0) |=> (phase_q == PH_WAIT));
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
    import extbus_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 16,
    parameter int WSEL_W    = 2,
    parameter int Q_PER_CYC = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [1:0]                 req_kind,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       wait_en,
    input  logic [WSEL_W-1:0]          wait_sel,
    input  logic [DATA_W-1:0]          ad_in,
    output logic [DATA_W-1:0]          ad_out,
    output logic                       ad_oe,
    output logic [ADDR_W-DATA_W-2:0]   addr_hi,
    output logic                       ale,
    output logic                       oe_n,
    output logic                       wr_n,
    output logic                       ce_n,
    output logic                       ba0,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       done
);
    localparam int HI_W = ADDR_W - DATA_W - 1;

    bus_phase_e        phase;
    logic              accept;
    logic [WSEL_W-1:0] wcyc_new, wcyc_q;
    bus_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rd_q;
    logic              is_wr, is_fetch;

    assign accept   = req_valid && (phase == PH_IDLE || phase == PH_LAST);
    assign is_wr    = (kind_q == KIND_TWR);
    assign is_fetch = (kind_q == KIND_FETCH);

    extbus_wait_dec #(.SEL_W(WSEL_W)) wait_dec_i (
        .en     (wait_en),
        .sel    (wait_sel),
        .cycles (wcyc_new)
    );

    extbus_phase_fsm #(.WCYC_W(WSEL_W), .Q_PER_CYC(Q_PER_CYC)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .wait_cycles (wcyc_q),
        .phase       (phase)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= KIND_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            wcyc_q  <= '0;
            rd_q    <= '0;
        end else begin
            if (accept) begin
                kind_q  <= bus_kind_e'(req_kind);
                addr_q  <= req_addr;
                wdata_q <= wr_data;
                wcyc_q  <= wcyc_new;
            end
            // capture at the edge that ends the closing phase, where oe_n rises
            if (phase == PH_LAST && !is_wr) rd_q <= ad_in;
        end
    end

    assign rd_data = rd_q;

    always_comb begin
        ad_out  = '0;
        ad_oe   = 1'b0;
        addr_hi = '0;
        ale     = 1'b0;
        oe_n    = 1'b1;
        wr_n    = 1'b1;
        ce_n    = 1'b1;
        ba0     = 1'b0;
        done    = 1'b0;
        unique case (phase)
            PH_IDLE: ;
            PH_ADDR: begin
                ce_n    = 1'b0;
                addr_hi = addr_q[ADDR_W-1 -: HI_W];
                ad_out  = addr_q[DATA_W:1];
                ad_oe   = 1'b1;
                ale     = 1'b1;
                ba0     = is_fetch ? 1'b0 : addr_q[0];
            end
            PH_TURN: begin
                ce_n    = 1'b0;
                addr_hi = addr_q[ADDR_W-1 -: HI_W];
                ba0     = is_fetch ? 1'b0 : addr_q[0];
            end
            PH_DATA, PH_WAIT, PH_LAST: begin
                ce_n    = 1'b0;
                addr_hi = addr_q[ADDR_W-1 -: HI_W];
                if (is_wr) begin
                    ad_oe  = 1'b1;
                    ad_out = wdata_q;
                    wr_n   = 1'b0;
                end else begin
                    oe_n   = 1'b0;
                end
                ba0  = is_fetch ? (phase == PH_DATA && addr_q[0]) : addr_q[0];
                done = (phase == PH_LAST);
            end
            default: ;
        endcase
    end

    // R6: read enable and write window never overlap
    p_oe_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !wr_n));
    // R4: oe_n only rises right after a closing phase
    p_oe_rise_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> $past(done));
    // R3: reads release the low lines once the address phase ends
    p_release_after_ale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ale) && !is_wr) |-> !ad_oe);
    // R2: upper address lines hold for the whole cycle after the address phase
    p_hi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !ale) |-> $stable(addr_hi));
    // R9: after a closing phase comes a new address phase or idle
    p_done_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ale || ce_n));
endmodule

// File: tb/extbus_seq_tb_top.sv
module extbus_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [20:0] req_addr;
    logic [15:0] wr_data;
    logic        wait_en;
    logic [1:0]  wait_sel;
    logic [15:0] ad_in;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  addr_hi;
    logic        ale, oe_n, wr_n, ce_n, ba0, done;
    logic [15:0] rd_data;

    int          checks = 0;
    int          fails  = 0;
    logic [15:0] exp_rd = 16'h0;
    logic [19:0] ext_lat = 20'h0;

    always #2 clk = ~clk;

    extbus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .wr_data(wr_data), .wait_en(wait_en),
        .wait_sel(wait_sel), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_hi(addr_hi), .ale(ale), .oe_n(oe_n), .wr_n(wr_n), .ce_n(ce_n),
        .ba0(ba0), .rd_data(rd_data), .done(done)
    );

    function automatic logic [15:0] mem_word(input logic [19:0] a);
        return a[15:0] ^ {a[3:0], a[19:16], a[11:4]} ^ 16'hC35A;
    endfunction

    // external address latch, transparent while ale is high
    always @(negedge clk) if (ale) ext_lat <= {addr_hi, ad_out};
    assign ad_in = oe_n ? 16'h0000 : mem_word(ext_lat);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, "ce_n", 32'(ce_n), 32'd1);
        chk(tag, "oe_n", 32'(oe_n), 32'd1);
        chk(tag, "wr_n", 32'(wr_n), 32'd1);
        chk(tag, "ale",  32'(ale),  32'd0);
        chk(tag, "ba0",  32'(ba0),  32'd0);
        chk(tag, "ad_oe", 32'(ad_oe), 32'd0);
        chk(tag, "done", 32'(done), 32'd0);
        chk(tag, "addr_hi", 32'(addr_hi), 32'd0);
    endtask

    task automatic txn(input logic [1:0] k, input logic [20:0] a,
                       input logic [15:0] wd, input logic we,
                       input logic [1:0] ws, input bit chained_in,
                       input bit chain_out, input bit poke);
        int  n, len;
        bit  wr, fe;
        if (!chained_in) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a;
        wr_data = wd; wait_en = we; wait_sel = ws;
        n   = we ? (3 - int'(ws)) : 0;
        len = 4 + 4 * n;
        wr  = (k == 2'b10);
        fe  = (k == 2'b00);
        for (int p = 0; p < len; p++) begin
            @(negedge clk);
            if (p == 0) req_valid = 1'b0;
            chk("R2", "ale", 32'(ale), 32'(p == 0));
            chk("R2", "ce_n", 32'(ce_n), 32'd0);
            chk("R2", "addr_hi", 32'(addr_hi), 32'(a[20:17]));
            if (p == 0) begin
                chk("R2", "ad_oe", 32'(ad_oe), 32'd1);
                chk("R2", "ad_out", 32'(ad_out), 32'(a[16:1]));
            end else if (wr && p >= 2) begin
                chk("R6", "ad_oe", 32'(ad_oe), 32'd1);
                chk("R6", "ad_out", 32'(ad_out), 32'(wd));
                chk("R6", "wr_n", 32'(wr_n), 32'd0);
                chk("R6", "oe_n", 32'(oe_n), 32'd1);
            end else if (wr) begin
                chk("R6", "ad_oe", 32'(ad_oe), 32'd0);
                chk("R6", "oe_n", 32'(oe_n), 32'd1);
            end else begin
                chk("R3", "ad_oe", 32'(ad_oe), 32'd0);
                chk("R3", "oe_n", 32'(oe_n), 32'(p < 2));
                chk("R6", "wr_n", 32'(wr_n), 32'd1);
            end
            if (p == 0 && !wr) chk("R3", "oe_n", 32'(oe_n), 32'd1);
            chk("R5", "ba0", 32'(ba0), fe ? 32'(a[0] && p == 2) : 32'(a[0]));
            chk(we ? "R7" : "R8", "done", 32'(done), 32'(p == len - 1));
            if (poke && p == 1) begin
                req_valid = 1'b1; req_kind = 2'($urandom); req_addr = 21'($urandom);
            end
            if (poke && p == 2) req_valid = 1'b0;
        end
        if (!wr) exp_rd = mem_word(a[20:1]);
        if (!chain_out) begin
            @(negedge clk);
            chk_idle("R9");
            chk("R4", "rd_data", 32'(rd_data), 32'(exp_rd));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit chain_prev;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0;
        wr_data = '0; wait_en = 1'b0; wait_sel = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        chk("R1", "rd_data", 32'(rd_data), 32'd0);

        // directed corners
        txn(2'b00, 21'h0ABCD5, 16'h0, 1'b0, 2'b00, 0, 0, 0); // R5 odd fetch, R8
        txn(2'b00, 21'h1E0002, 16'h0, 1'b1, 2'b11, 0, 0, 0); // R7 zero waits
        txn(2'b01, 21'h199E67, 16'h0, 1'b1, 2'b00, 0, 0, 0); // R7 three blocks
        txn(2'b10, 21'h030003, 16'hA5A5, 1'b1, 2'b10, 0, 0, 0); // R6 + R4 unchanged
        txn(2'b10, 21'h030002, 16'h3636, 1'b0, 2'b00, 0, 0, 0); // R8
        txn(2'b01, 21'h007556, 16'h0, 1'b1, 2'b01, 0, 0, 1);    // R9 ignored poke
        // R9 back-to-back chain: read, write, fetch
        txn(2'b01, 21'h15A5A1, 16'h0, 1'b0, 2'b00, 0, 1, 0);
        txn(2'b10, 21'h0F0F0F, 16'h1234, 1'b1, 2'b10, 1, 1, 0);
        txn(2'b00, 21'h1FFFFF, 16'h0, 1'b1, 2'b01, 1, 0, 0);

        // constrained random
        chain_prev = 0;
        for (int i = 0; i < 80; i++) begin
            logic [1:0] k;
            bit co;
            k  = 2'($urandom % 3);
            co = ($urandom % 3) == 0;
            txn(k, 21'($urandom), 16'($urandom), 1'($urandom), 2'($urandom),
                chain_prev, co, ($urandom % 5) == 0);
            chain_prev = co;
        end
        if (chain_prev) txn(2'b01, 21'h000001, 16'h0, 1'b0, 2'b00, 1, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule